// File: doc/BRIEF.md
# Addressed Frame Receiver with Checksum

This block sits behind a UART receiver and pulls addressed frames out of the byte stream. A frame starts with a start-of-header code. An address byte follows, then a fixed number of payload bytes, and the frame ends with an 8-bit checksum byte. While the block waits for a frame, it throws away every byte that is not the header code. It compares the address byte with the node's own address as soon as that byte arrives. On a mismatch it drops the frame at once, without buffering the payload.

For a frame that matches, the payload bytes go into a parallel buffer and are added into a running sum. That sum starts from the address byte. When the checksum byte arrives, the block raises a one-cycle valid pulse if the sum agrees and a one-cycle error pulse if it does not. The block also latches the value of an external free-running timestamp at the moment the header byte is accepted. Logic further on can use that value to place a reply in a time slot measured from the start of the request. A framing error reported by the UART ends any frame in progress.

Top module: `frx_rx`

## Requirements
- R1: After reset, frame_ok and frame_bad are 0, hdr_stamp is 0 and every payload byte reads 0.
- R2: While waiting for a frame, any accepted byte that differs from HDR_CODE (default 8'h7E) is dropped. The block keeps waiting and none of its outputs change.
- R3: The cycle after a HDR_CODE byte is accepted while waiting, hdr_stamp equals the stamp_in value at that accepting clock edge. hdr_stamp keeps that value until the next header is accepted.
- R4: If the byte after the header differs from my_addr, the block returns to waiting. The payload and checksum bytes of that frame change no output, and no pulse follows.
- R5: When the byte that follows PAY_LEN payload bytes (default 8) equals the modulo-256 sum of the address byte and all payload bytes, frame_ok is 1 for exactly the one cycle after that byte is accepted.
- R6: When that checksum byte does not match, frame_bad is 1 for exactly the one cycle after it, and frame_ok stays 0. This also covers a frame whose address matches but whose checksum was built over a different address.
- R7: Payload byte i of a matching frame appears at pay_bytes[8*i+7:8*i] the cycle after it is accepted. pay_bytes changes at no other time.
- R8: A cycle with rx_ferr high ends any frame in progress and returns the block to waiting, with no pulse. A byte flagged by rx_ferr is not accepted.
- R9: frame_ok and frame_bad are never both high.
- R10: Cycles with byte_vld low do not advance the frame, however long the gap between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Byte from the UART receiver |
| byte_vld | input | 1 | byte_in holds a new byte this cycle |
| rx_ferr | input | 1 | UART framing error; aborts the frame |
| my_addr | input | 8 | This node's address |
| stamp_in | input | STAMP_W | Free-running timestamp |
| pay_bytes | output | 8*PAY_LEN | Payload buffer, byte i in bits 8*i+7:8*i |
| frame_ok | output | 1 | One-cycle pulse: checksum matched |
| frame_bad | output | 1 | One-cycle pulse: checksum mismatch |
| hdr_stamp | output | STAMP_W | stamp_in value captured at the last header byte |

## Verification
The assertions assume that my_addr does not change while a frame is in progress, and that a byte counts only when byte_vld is high in a cycle where rx_ferr is low. The bench keeps my_addr fixed. It inserts random idle gaps between bytes. The filler bytes it sends while the block is waiting never equal the header code. For frames aimed at other nodes it draws payload and checksum bytes that also avoid the header code, so the expected result does not depend on the block locking onto a stray header.

// File: rtl/frx_pkg.sv
package frx_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_ADDR = 2'd1,
      ST_BODY = 2'd2,
      ST_SUM  = 2'd3
   } frx_state_e;

   function automatic logic [BYTE_W-1:0] sum_add(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
      return acc + b;
   endfunction
endpackage

// File: rtl/frx_seq.sv
module frx_seq
   import frx_pkg::*;
#(
   parameter int unsigned PAY_LEN  = 8,
   parameter logic [7:0]  HDR_CODE = 8'h7E,
   parameter int unsigned IDX_W    = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              byte_vld,
   input  logic              rx_ferr,
   input  logic [BYTE_W-1:0] my_addr,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              hdr_hit,
   output logic              sum_ok,
   output logic              sum_bad
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_LEN - 1);

   frx_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] acc_q;
   logic              take;

   assign take    = byte_vld && !rx_ferr;
   assign hdr_hit = take && (state_q == ST_HUNT) && (byte_in == HDR_CODE);
   assign wr_en   = take && (state_q == ST_BODY);
   assign wr_idx  = idx_q;
   assign sum_ok  = take && (state_q == ST_SUM) && (byte_in == acc_q);
   assign sum_bad = take && (state_q == ST_SUM) && (byte_in != acc_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         idx_q   <= '0;
         acc_q   <= '0;
      end else if (rx_ferr) begin
         state_q <= ST_HUNT;
         idx_q   <= '0;
      end else if (byte_vld) begin
         unique case (state_q)
            ST_HUNT: if (byte_in == HDR_CODE) state_q <= ST_ADDR;
            ST_ADDR: begin
               if (byte_in == my_addr) begin
                  state_q <= ST_BODY;
                  acc_q   <= byte_in;
                  idx_q   <= '0;
               end else begin
                  state_q <= ST_HUNT;
               end
            end
            ST_BODY: begin
               acc_q <= sum_add(acc_q, byte_in);
               if (idx_q == LAST_IDX) begin
                  state_q <= ST_SUM;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_SUM:  state_q <= ST_HUNT;
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   // R8: a framing error always lands the sequencer back in hunt
   a_r8_ferr_abort: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ferr |=> (state_q == ST_HUNT));

   // R4: a mismatching address byte leaves no frame open
   a_r4_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && take && byte_in != my_addr) |=> (state_q == ST_HUNT));

   // R10: idle cycles hold the sequencer where it is
   a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !rx_ferr) |=> ($stable(state_q) && $stable(idx_q) && $stable(acc_q)));

   // R9: the two verdicts cannot occur together
   a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sum_ok, sum_bad, hdr_hit, wr_en}));
endmodule

// File: rtl/frx_paybuf.sv
module frx_paybuf
   import frx_pkg::*;
#(
   parameter int unsigned PAY_LEN = 8,
   parameter int unsigned IDX_W   = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [BYTE_W-1:0]         wr_byte,
   output logic [PAY_LEN*BYTE_W-1:0] pay_bytes
);
   for (genvar g = 0; g < PAY_LEN; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                               slot_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))    slot_q <= wr_byte;
      end
      assign pay_bytes[g*BYTE_W +: BYTE_W] = slot_q;
   end

   // R7: the buffer moves only on a payload write
   a_r7_buf_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pay_bytes));
endmodule

// File: rtl/frx_rx.sv
module frx_rx
   import frx_pkg::*;
#(
   parameter int unsigned PAY_LEN  = 8,
   parameter int unsigned STAMP_W  = 16,
   parameter logic [7:0]  HDR_CODE = 8'h7E
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [7:0]                byte_in,
   input  logic                      byte_vld,
   input  logic                      rx_ferr,
   input  logic [7:0]                my_addr,
   input  logic [STAMP_W-1:0]        stamp_in,
   output logic [PAY_LEN*8-1:0]      pay_bytes,
   output logic                      frame_ok,
   output logic                      frame_bad,
   output logic [STAMP_W-1:0]        hdr_stamp
);
   localparam int unsigned IDX_W = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1;

   if (PAY_LEN < 1 || PAY_LEN > 256) begin : g_bad_len
      $error("frx_rx: PAY_LEN must be within 1..256");
   end
   if (STAMP_W < 1) begin : g_bad_stamp
      $error("frx_rx: STAMP_W must be at least 1");
   end

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             hdr_hit;
   logic             sum_ok;
   logic             sum_bad;

   frx_seq #(.PAY_LEN(PAY_LEN), .HDR_CODE(HDR_CODE), .IDX_W(IDX_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_in  (byte_in),
      .byte_vld (byte_vld),
      .rx_ferr  (rx_ferr),
      .my_addr  (my_addr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .hdr_hit  (hdr_hit),
      .sum_ok   (sum_ok),
      .sum_bad  (sum_bad)
   );

   frx_paybuf #(.PAY_LEN(PAY_LEN), .IDX_W(IDX_W)) buf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_byte   (byte_in),
      .pay_bytes (pay_bytes)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_ok  <= 1'b0;
         frame_bad <= 1'b0;
         hdr_stamp <= '0;
      end else begin
         frame_ok  <= sum_ok;
         frame_bad <= sum_bad;
         if (hdr_hit) hdr_stamp <= stamp_in;
      end
   end

   // R9: verdicts are exclusive at the ports
   a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok && frame_bad));

   // R5: frame_ok lasts a single cycle
   a_r5_ok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);

   // R6: frame_bad lasts a single cycle
   a_r6_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bad |=> !frame_bad);

   // R3: the header stamp holds between headers
   a_r3_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_hit |=> $stable(hdr_stamp));

   // R8: a framing error never yields a verdict on the next cycle
   a_r8_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ferr |=> (!frame_ok && !frame_bad));
endmodule

// File: tb/frx_rx_tb.sv
module frx_rx_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          PL         = 8;
   localparam int          SW         = 16;
   localparam logic [7:0]  HDR        = 8'h7E;
   localparam logic [7:0]  NODE       = 8'h3C;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [7:0]        byte_in;
   logic              byte_vld;
   logic              rx_ferr;
   logic [7:0]        my_addr;
   logic [SW-1:0]     stamp_in;
   logic [PL*8-1:0]   pay_bytes;
   logic              frame_ok;
   logic              frame_bad;
   logic [SW-1:0]     hdr_stamp;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [PL*8-1:0] exp_pay;
   logic [SW-1:0]   exp_stamp;
   logic [SW-1:0]   seen_stamp;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) stamp_in <= '0;
      else        stamp_in <= stamp_in + 16'd3;
   end

   frx_rx #(.PAY_LEN(PL), .STAMP_W(SW), .HDR_CODE(HDR)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_in   (byte_in),
      .byte_vld  (byte_vld),
      .rx_ferr   (rx_ferr),
      .my_addr   (my_addr),
      .stamp_in  (stamp_in),
      .pay_bytes (pay_bytes),
      .frame_ok  (frame_ok),
      .frame_bad (frame_bad),
      .hdr_stamp (hdr_stamp)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] csum(input logic [7:0] a, input logic [PL*8-1:0] p);
      logic [7:0] s = a;
      for (int i = 0; i < PL; i++) s = s + p[i*8 +: 8];
      return s;
   endfunction

   function automatic logic [7:0] non_hdr();
      logic [7:0] b = 8'($urandom);
      if (b == HDR) b = b ^ 8'h01;
      return b;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drives one byte; returns at the negedge after the accepting edge
   task automatic send_byte(input logic [7:0] b, input bit ferr);
      @(negedge clk);
      byte_in  = b;
      byte_vld = 1'b1;
      rx_ferr  = ferr;
      @(posedge clk);
      #1 seen_stamp = stamp_in;
      @(negedge clk);
      byte_vld = 1'b0;
      rx_ferr  = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] addr, input logic [PL*8-1:0] p,
                             input logic [7:0] sum_addr, input bit flip, input int gap);
      bit match = (addr == NODE);
      logic [7:0] cs = csum(sum_addr, p) ^ (flip ? 8'h5A : 8'h00);
      if (!match && cs == HDR) cs = cs ^ 8'h01;
      send_byte(HDR, 1'b0);
      exp_stamp = seen_stamp;
      chk(hdr_stamp == exp_stamp, "R3 header stamp", 64'(hdr_stamp), 64'(exp_stamp));
      idle(gap);
      send_byte(addr, 1'b0);
      for (int i = 0; i < PL; i++) begin
         idle(gap);
         send_byte(p[i*8 +: 8], 1'b0);
         if (match) exp_pay[i*8 +: 8] = p[i*8 +: 8];
      end
      idle(gap);
      send_byte(cs, 1'b0);
      chk(frame_ok == (match && cs == csum(addr, p)), "R5 frame_ok after checksum",
          64'(frame_ok), 64'(match && cs == csum(addr, p)));
      chk(frame_bad == (match && cs != csum(addr, p)), "R6 frame_bad after checksum",
          64'(frame_bad), 64'(match && cs != csum(addr, p)));
      chk(pay_bytes == exp_pay, match ? "R7 payload" : "R4 payload untouched",
          64'(pay_bytes), 64'(exp_pay));
      chk(hdr_stamp == exp_stamp, "R3 stamp held", 64'(hdr_stamp), 64'(exp_stamp));
      @(negedge clk);
      chk(!frame_ok && !frame_bad, "R9 single-cycle pulse", 64'({frame_ok, frame_bad}), 64'd0);
   endtask

   function automatic logic [PL*8-1:0] rand_pay(input bit avoid_hdr);
      logic [PL*8-1:0] p;
      for (int i = 0; i < PL; i++) p[i*8 +: 8] = avoid_hdr ? non_hdr() : 8'($urandom);
      return p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [PL*8-1:0] p;
      logic [7:0] sum_before;
      void'($urandom(32'd20141013));
      rst_n    = 1'b0;
      byte_in  = '0;
      byte_vld = 1'b0;
      rx_ferr  = 1'b0;
      my_addr  = NODE;
      exp_pay  = '0;
      exp_stamp = '0;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R1
      chk(!frame_ok && !frame_bad, "R1 reset pulses", 64'({frame_ok, frame_bad}), 64'd0);
      chk(hdr_stamp == '0, "R1 reset stamp", 64'(hdr_stamp), 64'd0);
      chk(pay_bytes == '0, "R1 reset payload", 64'(pay_bytes), 64'd0);

      // R2: noise while hunting changes nothing
      for (int i = 0; i < 6; i++) send_byte(non_hdr(), 1'b0);
      chk(hdr_stamp == '0 && pay_bytes == '0 && !frame_ok && !frame_bad,
          "R2 noise ignored", 64'(hdr_stamp), 64'd0);

      // R5 plain good frame, back-to-back-ish
      send_frame(NODE, 64'h0706050403020100, NODE, 1'b0, 0);
      // R10 long gaps between bytes
      send_frame(NODE, rand_pay(1'b0), NODE, 1'b0, 7);
      // R6 checksum corrupted
      send_frame(NODE, rand_pay(1'b0), NODE, 1'b1, 1);
      // R6 checksum built over another address
      send_frame(NODE, rand_pay(1'b0), 8'h3D, 1'b0, 0);
      // R4 other node
      send_frame(8'h11, rand_pay(1'b1), 8'h11, 1'b0, 0);
      // R5 checksum wrap: all 0xFF payload
      send_frame(NODE, {PL{8'hFF}}, NODE, 1'b0, 0);

      // R8 framing error mid-payload
      p = rand_pay(1'b1);
      send_byte(HDR, 1'b0);
      exp_stamp = seen_stamp;
      send_byte(NODE, 1'b0);
      for (int i = 0; i < 3; i++) begin
         send_byte(p[i*8 +: 8], 1'b0);
         exp_pay[i*8 +: 8] = p[i*8 +: 8];
      end
      send_byte(HDR, 1'b1);
      chk(pay_bytes == exp_pay, "R8 flagged byte not stored", 64'(pay_bytes), 64'(exp_pay));
      chk(hdr_stamp == exp_stamp, "R8 flagged header ignored", 64'(hdr_stamp), 64'(exp_stamp));
      sum_before = csum(NODE, p);
      for (int i = 0; i < PL; i++) send_byte(non_hdr(), 1'b0);
      send_byte(sum_before, 1'b0);
      chk(!frame_ok && !frame_bad && pay_bytes == exp_pay, "R8 abort to hunt",
          64'({frame_ok, frame_bad}), 64'd0);
      send_frame(NODE, rand_pay(1'b0), NODE, 1'b0, 0);

      // random mix
      for (int k = 0; k < 60; k++) begin
         bit          mine = ($urandom % 2) == 0;
         logic [7:0]  a    = mine ? NODE : non_hdr();
         if (!mine && a == NODE) a = NODE ^ 8'h80;
         for (int j = 0; j < int'($urandom % 3); j++) send_byte(non_hdr(), 1'b0);
         send_frame(a, rand_pay(!mine), a, ($urandom % 4) == 0, int'($urandom % 3));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule